// File: doc/BRIEF.md
# Opcode Format Decoder

This block looks at the first byte of an instruction for a small 8-bit microcontroller and tells the rest of the core what kind of instruction it is, without executing anything. For every opcode it reports an operation class, the instruction length in bytes and the number of machine cycles. It also reports the operand fields packed into the opcode itself: a register number, an indirect pointer select, a port select, an expander-port select and the high address bits of a long jump or call.

A second input carries the byte that follows the opcode. When the instruction is two bytes long, the decoder uses that byte to build the immediate operand or the branch target. Long jumps and calls produce a full 11-bit target. Conditional branches produce an 8-bit offset within the current 256-byte page and flag it as page-relative, so the fetch unit keeps its own upper program-counter bits.

Where the operand fields sit depends on the opcode family. The decoder therefore first classifies the opcode into a format, and only then pulls out and validates the fields. An opcode outside the instruction set raises an illegal flag. The block is purely combinational.

Top module: `opc_format_decoder`

## Requirements
- R1: Register-direct opcodes (groups 0x18, 0x28, 0x48, 0x58, 0x68, 0x78, 0xA8, 0xB8, 0xD8, 0xE8, 0xF8, each covering eight opcodes) assert reg_v_o and give reg_o = opcode bits 2:0. At most one of reg_v_o, ptr_v_o, port_v_o and exp_v_o is high at any time.
- R2: Indirect opcodes (pairs at 0x20, 0x30, 0x40, 0x50, 0x60, 0x70, 0xA0, 0xB0, 0xD0, 0xF0) assert ptr_v_o and give ptr_o = opcode bit 0.
- R3: Long jump (opcodes with low five bits 00100) and call (low five bits 10100) give class 3 and class 4 respectively. Both give tgt_v_o=1, tgt_page_o=0, tgt_o = {opcode[7:5], next byte}, length 2 and cycles 2.
- R4: Conditional branches (0x16, 0x56, 0x96, 0xC6, 0xE6, 0xF6) and decrement-and-branch (0xE8-0xEF, which also carries a register) give class 5, length 2, cycles 2, tgt_v_o=1 and tgt_page_o=1, with tgt_o = next byte zero-extended.
- R5: Expander-port opcodes (0x0C-0x0F, 0x3C-0x3F, 0x8C-0x8F, 0x9C-0x9F) give class 8, exp_v_o=1, exp_o = opcode bits 1:0, length 1 and cycles 2.
- R6: Port I/O opcodes 0x09, 0x0A, 0x39 and 0x3A give class 7, port_v_o=1, port_o = opcode bits 1:0 (1 selects port 1, 2 selects port 2), length 1 and cycles 2. The same groups with bits 1:0 equal to 00 or 11 are illegal.
- R7: Immediate opcodes give imm_v_o=1 and imm_o = next byte, with length 2 and cycles 2. These are 0x03, 0x13, 0x43, 0x53 and 0xD3 (class 1), 0x23 (class 2), and the immediate-to-register and immediate-to-memory moves. Every two-byte instruction takes two cycles.
- R8: One-byte implied opcodes report length 1. Return 0x83 gives class 6 with cycles 2. Table read 0xA3 and accumulator jump 0xB3 give cycles 2. NOP 0x00 gives class 9 with cycles 1. Register and indirect accumulator operations such as 0x6D and 0x61 give length 1, cycles 1 and class 1.
- R9: Any opcode outside the set raises illegal_o and gives class 0, length 1, cycles 1, and no valid flags. Examples are 0x01, 0x0B and 0x88.
- R10: With the default ZERO_UNUSED=1, every operand field whose valid flag is low reads zero. For example, reg_o=0 for jump 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | First instruction byte (opcode) |
| nxt_i | input | 8 | Byte following the opcode |
| class_o | output | 4 | Operation class (0 illegal, 1 ALU, 2 move, 3 jump, 4 call, 5 branch, 6 return, 7 port, 8 expander, 9 control) |
| len_o | output | 2 | Instruction length in bytes |
| cyc_o | output | 2 | Machine cycles |
| illegal_o | output | 1 | Opcode not in the set |
| reg_v_o | output | 1 | Register field valid |
| reg_o | output | 3 | Register number |
| ptr_v_o | output | 1 | Indirect pointer field valid |
| ptr_o | output | 1 | Indirect pointer select |
| port_v_o | output | 1 | Port field valid |
| port_o | output | 2 | Port select |
| exp_v_o | output | 1 | Expander-port field valid |
| exp_o | output | 2 | Expander-port select |
| tgt_v_o | output | 1 | Branch target valid |
| tgt_page_o | output | 1 | Target is page-relative |
| tgt_o | output | ADDR_W | Branch target address |
| imm_v_o | output | 1 | Immediate valid |
| imm_o | output | 8 | Immediate operand |

## Verification
Some rules tie the decode tables together, and the embedded assertions check these whenever the inputs change. Two-byte instructions always take two cycles. An illegal opcode reports a one-byte, one-cycle instruction with no valid fields. A target or immediate only appears on a two-byte instruction. Page-relative targets have clear upper bits. At most one small operand field is valid, and unused fields read zero. Whether a given opcode lands in the right class, where its field is taken from, and how the next byte becomes a target are things the assertions cannot see. Only the bench's directed opcodes with known expected values can show them.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

   localparam int OP_W  = 8;
   localparam int LEN_W = 2;
   localparam int CYC_W = 2;
   localparam int CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CL_ILLEGAL  = 4'd0,
      CL_ALU      = 4'd1,
      CL_MOVE     = 4'd2,
      CL_JUMP     = 4'd3,
      CL_CALL     = 4'd4,
      CL_BRANCH   = 4'd5,
      CL_RETURN   = 4'd6,
      CL_PORT     = 4'd7,
      CL_EXPANDER = 4'd8,
      CL_CONTROL  = 4'd9
   } op_class_e;

   // Where the operand fields live for a given opcode family
   typedef enum logic [3:0] {
      FMT_NONE,
      FMT_REG,
      FMT_IND,
      FMT_IMM,
      FMT_FAR,
      FMT_NEAR,
      FMT_REG_NEAR,
      FMT_PORT,
      FMT_EXP,
      FMT_REG_IMM,
      FMT_IND_IMM
   } op_fmt_e;

   typedef struct packed {
      op_class_e        cls;
      op_fmt_e          fmt;
      logic [LEN_W-1:0] len;
      logic [CYC_W-1:0] cyc;
   } dec_t;

   function automatic dec_t mk(op_class_e c, op_fmt_e f, int l, int n);
      dec_t d;
      d.cls = c;
      d.fmt = f;
      d.len = LEN_W'(l);
      d.cyc = CYC_W'(n);
      return d;
   endfunction

endpackage

// File: rtl/ofd_family.sv
module ofd_family
   import ofd_pkg::*;
(
   input  logic [OP_W-1:0]  op_i,
   output op_class_e        cls_o,
   output op_fmt_e          fmt_o,
   output logic [LEN_W-1:0] len_o,
   output logic [CYC_W-1:0] cyc_o,
   output logic             illegal_o
);

   dec_t d;

   always_comb begin
      casez (op_i)
         // register-direct groups
         8'b0110_1???, 8'b0111_1???, 8'b0101_1???, 8'b0001_1???,
         8'b0100_1???, 8'b1101_1???:  d = mk(CL_ALU,  FMT_REG, 1, 1);
         8'b1111_1???, 8'b1010_1???,
         8'b0010_1???:                d = mk(CL_MOVE, FMT_REG, 1, 1);
         8'b1011_1???:                d = mk(CL_MOVE, FMT_REG_IMM, 2, 2);
         8'b1110_1???:                d = mk(CL_BRANCH, FMT_REG_NEAR, 2, 2);
         // indirect groups
         8'b0110_000?, 8'b0111_000?, 8'b0101_000?, 8'b0100_000?,
         8'b1101_000?:                d = mk(CL_ALU,  FMT_IND, 1, 1);
         8'b1111_000?, 8'b1010_000?, 8'b0010_000?,
         8'b0011_000?:                d = mk(CL_MOVE, FMT_IND, 1, 1);
         8'b1011_000?:                d = mk(CL_MOVE, FMT_IND_IMM, 2, 2);
         // immediate to accumulator
         8'h03, 8'h13, 8'h43, 8'h53,
         8'hD3:                       d = mk(CL_ALU,  FMT_IMM, 2, 2);
         8'h23:                       d = mk(CL_MOVE, FMT_IMM, 2, 2);
         // expander and port transfers
         8'b0000_11??, 8'b0011_11??, 8'b1000_11??,
         8'b1001_11??:                d = mk(CL_EXPANDER, FMT_EXP, 1, 2);
         8'h09, 8'h0A, 8'h39, 8'h3A:  d = mk(CL_PORT, FMT_PORT, 1, 2);
         // long transfers: page bits in the top three opcode bits
         8'b???0_0100:                d = mk(CL_JUMP, FMT_FAR, 2, 2);
         8'b???1_0100:                d = mk(CL_CALL, FMT_FAR, 2, 2);
         // in-page conditional branches
         8'h16, 8'h56, 8'h96, 8'hC6, 8'hE6,
         8'hF6:                       d = mk(CL_BRANCH, FMT_NEAR, 2, 2);
         // implied single-byte forms
         8'h83:                       d = mk(CL_RETURN, FMT_NONE, 1, 2);
         8'hB3:                       d = mk(CL_JUMP, FMT_NONE, 1, 2);
         8'hA3:                       d = mk(CL_MOVE, FMT_NONE, 1, 2);
         8'h42, 8'h62:                d = mk(CL_MOVE, FMT_NONE, 1, 1);
         8'h27, 8'h37, 8'h57, 8'h07, 8'h17, 8'hE7, 8'hF7, 8'h77,
         8'h67, 8'h47:                d = mk(CL_ALU, FMT_NONE, 1, 1);
         8'h00, 8'h97, 8'hA7, 8'h85, 8'hA5, 8'h95, 8'hB5, 8'h65,
         8'h45, 8'h55:                d = mk(CL_CONTROL, FMT_NONE, 1, 1);
         default:                     d = mk(CL_ILLEGAL, FMT_NONE, 1, 1);
      endcase
   end

   assign cls_o     = d.cls;
   assign fmt_o     = d.fmt;
   assign len_o     = d.len;
   assign cyc_o     = d.cyc;
   assign illegal_o = (d.cls == CL_ILLEGAL);

   always_comb begin
      // R9
      illegal_shape_chk: assert (!illegal_o || (len_o == LEN_W'(1) && cyc_o == CYC_W'(1) && fmt_o == FMT_NONE))
         else $error("illegal opcode reports wrong shape");
      // R7
      two_byte_cycles_chk: assert (len_o != LEN_W'(2) || cyc_o == CYC_W'(2))
         else $error("two-byte instruction not two cycles");
   end

endmodule

// File: rtl/ofd_fields.sv
module ofd_fields
   import ofd_pkg::*;
#(
   parameter bit ZERO_UNUSED = 1'b1
)(
   input  logic [OP_W-1:0] op_i,
   input  logic [OP_W-1:0] nxt_i,
   input  op_fmt_e         fmt_i,
   output logic            reg_v_o,
   output logic [2:0]      reg_o,
   output logic            ptr_v_o,
   output logic            ptr_o,
   output logic            port_v_o,
   output logic [1:0]      port_o,
   output logic            exp_v_o,
   output logic [1:0]      exp_o,
   output logic            imm_v_o,
   output logic [OP_W-1:0] imm_o
);

   always_comb begin
      reg_v_o  = (fmt_i == FMT_REG) || (fmt_i == FMT_REG_NEAR) || (fmt_i == FMT_REG_IMM);
      ptr_v_o  = (fmt_i == FMT_IND) || (fmt_i == FMT_IND_IMM);
      port_v_o = (fmt_i == FMT_PORT);
      exp_v_o  = (fmt_i == FMT_EXP);
      imm_v_o  = (fmt_i == FMT_IMM) || (fmt_i == FMT_REG_IMM) || (fmt_i == FMT_IND_IMM);
   end

   generate
      if (ZERO_UNUSED) begin : g_masked
         assign reg_o  = reg_v_o  ? op_i[2:0] : 3'd0;
         assign ptr_o  = ptr_v_o  ? op_i[0]   : 1'b0;
         assign port_o = port_v_o ? op_i[1:0] : 2'd0;
         assign exp_o  = exp_v_o  ? op_i[1:0] : 2'd0;
         assign imm_o  = imm_v_o  ? nxt_i     : '0;

         always_comb begin
            // R10
            unused_zero_chk: assert ((reg_v_o || reg_o == 3'd0) && (ptr_v_o || !ptr_o) &&
                                     (port_v_o || port_o == 2'd0) && (exp_v_o || exp_o == 2'd0) &&
                                     (imm_v_o || imm_o == '0))
               else $error("unused field not zero");
         end
      end else begin : g_raw
         assign reg_o  = op_i[2:0];
         assign ptr_o  = op_i[0];
         assign port_o = op_i[1:0];
         assign exp_o  = op_i[1:0];
         assign imm_o  = nxt_i;
      end
   endgenerate

   always_comb begin
      // R1
      one_field_chk: assert ($onehot0({reg_v_o, ptr_v_o, port_v_o, exp_v_o}))
         else $error("more than one operand field valid");
   end

endmodule

// File: rtl/ofd_target.sv
module ofd_target
   import ofd_pkg::*;
#(
   parameter int ADDR_W = 11
)(
   input  logic [OP_W-1:0]   op_i,
   input  logic [OP_W-1:0]   nxt_i,
   input  op_fmt_e           fmt_i,
   output logic              tgt_v_o,
   output logic              tgt_page_o,
   output logic [ADDR_W-1:0] tgt_o
);

   localparam int HI_W = ADDR_W - OP_W;

   logic far_q;
   logic near_q;

   assign far_q      = (fmt_i == FMT_FAR);
   assign near_q     = (fmt_i == FMT_NEAR) || (fmt_i == FMT_REG_NEAR);
   assign tgt_v_o    = far_q || near_q;
   assign tgt_page_o = near_q;

   always_comb begin
      if (far_q)       tgt_o = {op_i[OP_W-1 -: HI_W], nxt_i};
      else if (near_q) tgt_o = {{HI_W{1'b0}}, nxt_i};
      else             tgt_o = '0;
   end

endmodule

// File: rtl/opc_format_decoder.sv
module opc_format_decoder
   import ofd_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter bit ZERO_UNUSED = 1'b1
)(
   input  logic [7:0]        op_i,
   input  logic [7:0]        nxt_i,
   output logic [3:0]        class_o,
   output logic [1:0]        len_o,
   output logic [1:0]        cyc_o,
   output logic              illegal_o,
   output logic              reg_v_o,
   output logic [2:0]        reg_o,
   output logic              ptr_v_o,
   output logic              ptr_o,
   output logic              port_v_o,
   output logic [1:0]        port_o,
   output logic              exp_v_o,
   output logic [1:0]        exp_o,
   output logic              tgt_v_o,
   output logic              tgt_page_o,
   output logic [ADDR_W-1:0] tgt_o,
   output logic              imm_v_o,
   output logic [7:0]        imm_o
);

   localparam int HI_W = ADDR_W - OP_W;

   generate
      if (HI_W != 3) begin : g_bad_addr
         $error("ADDR_W must be 11: three page bits come from the opcode");
      end
   endgenerate

   op_class_e cls_w;
   op_fmt_e   fmt_w;

   ofd_family u_family (
      .op_i      (op_i),
      .cls_o     (cls_w),
      .fmt_o     (fmt_w),
      .len_o     (len_o),
      .cyc_o     (cyc_o),
      .illegal_o (illegal_o)
   );

   ofd_fields #(.ZERO_UNUSED(ZERO_UNUSED)) u_fields (
      .op_i     (op_i),
      .nxt_i    (nxt_i),
      .fmt_i    (fmt_w),
      .reg_v_o  (reg_v_o),
      .reg_o    (reg_o),
      .ptr_v_o  (ptr_v_o),
      .ptr_o    (ptr_o),
      .port_v_o (port_v_o),
      .port_o   (port_o),
      .exp_v_o  (exp_v_o),
      .exp_o    (exp_o),
      .imm_v_o  (imm_v_o),
      .imm_o    (imm_o)
   );

   ofd_target #(.ADDR_W(ADDR_W)) u_target (
      .op_i       (op_i),
      .nxt_i      (nxt_i),
      .fmt_i      (fmt_w),
      .tgt_v_o    (tgt_v_o),
      .tgt_page_o (tgt_page_o),
      .tgt_o      (tgt_o)
   );

   assign class_o = cls_w;

   always_comb begin
      // R3
      target_len_chk: assert (!tgt_v_o || len_o == 2'd2)
         else $error("target on a one-byte instruction");
      // R4
      page_upper_chk: assert (!tgt_page_o || (tgt_v_o && tgt_o[ADDR_W-1:8] == '0))
         else $error("page-relative target has upper bits");
      // R7
      imm_len_chk: assert (!imm_v_o || len_o == 2'd2)
         else $error("immediate on a one-byte instruction");
      // R9
      illegal_quiet_chk: assert (!illegal_o || !(reg_v_o || ptr_v_o || port_v_o || exp_v_o || tgt_v_o || imm_v_o))
         else $error("illegal opcode has a valid field");
   end

endmodule

// File: tb/opc_format_decoder_tb.sv
module opc_format_decoder_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [7:0]  op, nxt;
   logic [3:0]  class_o;
   logic [1:0]  len_o, cyc_o, port_o, exp_o;
   logic        illegal_o, reg_v_o, ptr_v_o, ptr_o, port_v_o, exp_v_o, tgt_v_o, tgt_page_o, imm_v_o;
   logic [2:0]  reg_o;
   logic [10:0] tgt_o;
   logic [7:0]  imm_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   opc_format_decoder u_dut (
      .op_i(op), .nxt_i(nxt), .class_o(class_o), .len_o(len_o), .cyc_o(cyc_o),
      .illegal_o(illegal_o), .reg_v_o(reg_v_o), .reg_o(reg_o), .ptr_v_o(ptr_v_o),
      .ptr_o(ptr_o), .port_v_o(port_v_o), .port_o(port_o), .exp_v_o(exp_v_o),
      .exp_o(exp_o), .tgt_v_o(tgt_v_o), .tgt_page_o(tgt_page_o), .tgt_o(tgt_o),
      .imm_v_o(imm_v_o), .imm_o(imm_o)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(logic [7:0] o, logic [7:0] n);
      @(negedge clk);
      op  = o;
      nxt = n;
      #2;
   endtask

   task automatic shape(string req, int cls, int len, int cyc);
      chk(req, "class", class_o, cls);
      chk(req, "len", len_o, len);
      chk(req, "cyc", cyc_o, cyc);
      chk(req, "illegal", illegal_o, cls == 0);
   endtask

   task automatic t_reset;
      apply(8'h00, 8'h00);
      // R8 NOP after reset
      shape("R8", 9, 1, 1);
      chk("R8", "tgt_v", tgt_v_o, 0);
   endtask

   task automatic t_register;
      apply(8'h6D, 8'h55);
      shape("R8", 1, 1, 1);
      chk("R1", "reg_v", reg_v_o, 1);
      chk("R1", "reg", reg_o, 5);
      chk("R1", "ptr_v", ptr_v_o, 0);
      chk("R10", "imm", imm_o, 0);
      apply(8'hBA, 8'h9C);
      chk("R1", "reg", reg_o, 2);
      shape("R7", 2, 2, 2);
      chk("R7", "imm", imm_o, 8'h9C);
      chk("R7", "imm_v", imm_v_o, 1);
   endtask

   task automatic t_indirect;
      apply(8'h61, 8'h00);
      shape("R8", 1, 1, 1);
      chk("R2", "ptr_v", ptr_v_o, 1);
      chk("R2", "ptr", ptr_o, 1);
      chk("R2", "reg_v", reg_v_o, 0);
      apply(8'hB0, 8'h3E);
      chk("R2", "ptr", ptr_o, 0);
      chk("R2", "ptr_v", ptr_v_o, 1);
      shape("R7", 2, 2, 2);
      chk("R7", "imm", imm_o, 8'h3E);
   endtask

   task automatic t_far;
      apply(8'hA4, 8'h3C);
      shape("R3", 3, 2, 2);
      chk("R3", "tgt", tgt_o, 11'h53C);
      chk("R3", "page", tgt_page_o, 0);
      chk("R10", "reg", reg_o, 0);
      apply(8'hF4, 8'h12);
      shape("R3", 4, 2, 2);
      chk("R3", "tgt", tgt_o, 11'h712);
      apply(8'h14, 8'hFF);
      chk("R3", "tgt", tgt_o, 11'h0FF);
      chk("R3", "class", class_o, 4);
   endtask

   task automatic t_near;
      apply(8'hC6, 8'h77);
      shape("R4", 5, 2, 2);
      chk("R4", "tgt_v", tgt_v_o, 1);
      chk("R4", "page", tgt_page_o, 1);
      chk("R4", "tgt", tgt_o, 11'h077);
      apply(8'hEB, 8'hF0);
      shape("R4", 5, 2, 2);
      chk("R4", "tgt", tgt_o, 11'h0F0);
      chk("R1", "reg", reg_o, 3);
      chk("R4", "imm_v", imm_v_o, 0);
   endtask

   task automatic t_ports;
      apply(8'h9E, 8'h00);
      shape("R5", 8, 1, 2);
      chk("R5", "exp_v", exp_v_o, 1);
      chk("R5", "exp", exp_o, 2);
      apply(8'h0F, 8'h00);
      chk("R5", "exp", exp_o, 3);
      apply(8'h3A, 8'h00);
      shape("R6", 7, 1, 2);
      chk("R6", "port", port_o, 2);
      apply(8'h09, 8'h00);
      chk("R6", "port", port_o, 1);
      chk("R6", "port_v", port_v_o, 1);
      apply(8'h3B, 8'h00);
      shape("R6", 0, 1, 1);
   endtask

   task automatic t_immediate;
      apply(8'hD3, 8'hA5);
      shape("R7", 1, 2, 2);
      chk("R7", "imm", imm_o, 8'hA5);
      apply(8'h23, 8'h5A);
      shape("R7", 2, 2, 2);
      chk("R7", "imm", imm_o, 8'h5A);
   endtask

   task automatic t_implied;
      apply(8'h83, 8'h44);
      shape("R8", 6, 1, 2);
      chk("R8", "imm_v", imm_v_o, 0);
      apply(8'hA3, 8'h00);
      chk("R8", "cyc", cyc_o, 2);
      chk("R8", "len", len_o, 1);
      apply(8'hB3, 8'h00);
      chk("R8", "cyc", cyc_o, 2);
      chk("R8", "tgt_v", tgt_v_o, 0);
   endtask

   task automatic t_illegal;
      logic [7:0] bad [3] = '{8'h01, 8'h0B, 8'h88};
      for (int i = 0; i < 3; i++) begin
         apply(bad[i], 8'hFF);
         shape("R9", 0, 1, 1);
         chk("R9", "valids", {reg_v_o, ptr_v_o, port_v_o, exp_v_o, tgt_v_o, imm_v_o}, 0);
         chk("R10", "fields", {reg_o, ptr_o, port_o, exp_o, imm_o}, 0);
      end
   endtask

   task automatic t_sweep;
      for (int i = 0; i < 256; i++) begin
         apply(8'(i), 8'(255 - i));
         // R7 every two-byte form is two cycles
         if (len_o == 2'd2) chk("R7", "sweep cyc", cyc_o, 2);
         // R9 illegal shape across all codes
         if (illegal_o) chk("R9", "sweep len", len_o, 1);
      end
   endtask

   initial begin
      op = 8'h00;
      nxt = 8'h00;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_register();
      t_indirect();
      t_far();
      t_near();
      t_ports();
      t_immediate();
      t_implied();
      t_illegal();
      t_sweep();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule